// File: doc/BRIEF.md
# Addressed SPI Frame Master

This block turns one host request into one complete register-access frame on an SPI link to a network controller. The request names a 16-bit starting offset, a 5-bit area selector, a direction and a byte count. While chip select is held low, the block sends three things in order: the offset, a control byte, and then the data burst. The SPI bus runs in mode 0, with the serial clock divided down from the system clock.

For a write, the data bytes are pulled one at a time from a host write stream that uses a valid/ready handshake. When the stream has no byte ready, the serial clock stops and chip select stays low until a byte arrives. For a read, the block sends zero bytes as filler. Each byte it captures is handed to the host as a single-cycle pulse on the read stream.

The area selector works as an upper extension of the offset. The slave stores each data byte at the next offset in turn, so the block sends the starting offset once and never recomputes it.

Top module: `addr_spi_master`

## Requirements
- R1: After reset, csN is 1, sclk is 0, busy is 0, errPulse is 0 and reqReady is 1.
- R2: The first two bytes of every frame carry reqOffset, most significant bit first (0x0040 goes out as 0000_0000_0100_0000).
- R3: The third byte is the control byte {reqBlock[4:0], reqWrite, 2'b00}, sent MSB first. reqWrite = 1 means write, and 2'b00 selects variable-length data mode.
- R4: A write frame holds exactly 3 + reqLen bytes while csN is low. The data bytes are the next reqLen words taken from the write stream (wrValid && wrReady), in the order they were taken.
- R5: A read frame sends reqLen bytes of 0x00 after the control byte. Each byte sampled on miso (MSB first) appears on rdData with a one-cycle rdValid, in frame order, and only while csN is low.
- R6: A request with reqLen = 0 is consumed and answered with errPulse = 1 for exactly one cycle. No frame is started: csN stays high and busy stays low.
- R7: Mode 0 timing holds. sclk is low whenever csN is high. mosi holds steady while sclk is high, and changes only during the low phase.
- R8: Every high phase of sclk lasts exactly HALF_DIV system clock cycles.
- R9: A request is accepted on a cycle where reqValid and reqReady are both 1. Offset, selector, direction and count are captured at that moment, and later changes to those inputs have no effect on the frame. From the cycle after acceptance until csN rises, busy is 1 and reqReady is 0.
- R10: In a write frame, if wrReady is 1 while wrValid is 0, sclk stays low until the byte is supplied. The frame content is not disturbed by the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqOffset | input | 16 | Starting offset inside the selected area |
| reqBlock | input | 5 | Area selector placed in the control byte |
| reqWrite | input | 1 | 1 = write frame, 0 = read frame |
| reqLen | input | LEN_W | Number of data bytes (0 is rejected) |
| wrData | input | 8 | Write stream byte |
| wrValid | input | 1 | Write stream byte valid |
| wrReady | output | 1 | Block is taking a write byte this cycle |
| rdData | output | 8 | Captured read byte |
| rdValid | output | 1 | One-cycle strobe for rdData |
| busy | output | 1 | A frame is in progress |
| errPulse | output | 1 | One-cycle flag for a zero-length request |
| sclk | output | 1 | SPI serial clock, idles low |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
A header byte counter stuck on the wrong value shows up in the first frame as swapped offset and control bytes. A data counter off by one shows up as a frame one byte too long or too short when csN rises. A shift-register or bit-counter fault corrupts the very next byte on mosi or rdData. A divider or phase fault shows up within one sclk period as a wrong high-phase length, or as mosi moving while sclk is high. The bench models the slave bit by bit, so every one of these faults is seen in the frame where it first occurs.

// File: rtl/asm_pkg.sv
package asm_pkg;

  // Source chosen when the transmit shift register is loaded
  typedef enum logic [1:0] {
    SEL_ADDR_HI = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_DATA    = 2'd3
  } byteSel_e;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic     capture;  // latch request fields
    logic     load;     // load transmit shift register
    byteSel_e sel;      // load source
    logic     shift;    // advance mosi on falling sclk
    logic     sample;   // take miso on rising sclk
    logic     push;     // hand received byte to host
  } dpStrobe_t;

  // Variable-length data mode code in the control byte
  localparam logic [1:0] OM_VARIABLE = 2'b00;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } ctlState_e;

endpackage

// File: rtl/asm_datapath.sv
module asm_datapath
  import asm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic [15:0] reqOffset,
  input  logic [4:0]  reqBlock,
  input  logic        reqWrite,
  input  logic [7:0]  wrData,
  input  logic        miso,
  output logic        mosi,
  output logic [7:0]  rdData,
  output logic        rdValid
);

  logic [15:0] offsetQ;
  logic [7:0]  ctrlQ;
  logic [7:0]  txShift;
  logic [7:0]  rxShift;
  logic [7:0]  rdDataQ;
  logic        rdValidQ;
  logic [7:0]  loadByte;

  // Source of the next byte for the transmit shift register
  always_comb begin
    unique case (strobe.sel)
      SEL_ADDR_HI: loadByte = offsetQ[15:8];
      SEL_ADDR_LO: loadByte = offsetQ[7:0];
      SEL_CTRL:    loadByte = ctrlQ;
      default:     loadByte = ctrlQ[2] ? wrData : 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetQ <= '0;
      ctrlQ   <= '0;
    end else if (strobe.capture) begin
      offsetQ <= reqOffset;
      ctrlQ   <= {reqBlock, reqWrite, OM_VARIABLE};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.load) begin
      txShift <= loadByte;
    end else if (strobe.shift) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strobe.sample) begin
      rxShift <= {rxShift[6:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strobe.push;
      if (strobe.push) rdDataQ <= rxShift;
    end
  end

  assign mosi    = txShift[7];
  assign rdData  = rdDataQ;
  assign rdValid = rdValidQ;

endmodule

// File: rtl/asm_control.sv
module asm_control
  import asm_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             wrValid,
  output logic             reqReady,
  output logic             wrReady,
  output dpStrobe_t        strobe,
  output logic             sclk,
  output logic             csN,
  output logic             busy,
  output logic             errPulse
);

  localparam int DIV_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

  ctlState_e        state;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [1:0]       hdrCnt;   // 0..2 header bytes, 3 = data bytes
  logic [LEN_W-1:0] dataLeft;
  logic             writeQ;
  logic             sclkQ;
  logic             errQ;

  logic isData, divDone, loadOk, fallEdge, lastBit, lastByte, accept;

  assign isData   = (hdrCnt == 2'd3);
  assign divDone  = (divCnt == DIV_LAST);
  assign loadOk   = (state == ST_LOAD) && (!(isData && writeQ) || wrValid);
  assign fallEdge = (state == ST_SHIFT) && divDone && sclkQ;
  assign lastBit  = (bitCnt == 3'd7);
  assign lastByte = isData && (dataLeft == LEN_ONE);
  assign accept   = (state == ST_IDLE) && reqValid;

  assign reqReady = (state == ST_IDLE);
  assign wrReady  = (state == ST_LOAD) && isData && writeQ;
  assign busy     = (state != ST_IDLE);
  assign csN      = (state == ST_IDLE);
  assign sclk     = sclkQ;
  assign errPulse = errQ;

  always_comb begin
    strobe         = '0;
    strobe.capture = accept && (reqLen != '0);
    strobe.load    = loadOk;
    strobe.sel     = isData ? SEL_DATA : byteSel_e'(hdrCnt);
    strobe.sample  = (state == ST_SHIFT) && divDone && !sclkQ;
    strobe.shift   = fallEdge && !lastBit;
    strobe.push    = fallEdge && lastBit && isData && !writeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      bitCnt   <= '0;
      hdrCnt   <= '0;
      dataLeft <= '0;
      writeQ   <= 1'b0;
      sclkQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      errQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (reqLen == '0) begin
              errQ <= 1'b1;
            end else begin
              state    <= ST_LOAD;
              hdrCnt   <= 2'd0;
              dataLeft <= reqLen;
              writeQ   <= reqWrite;
            end
          end
        end
        ST_LOAD: begin
          if (loadOk) begin
            state  <= ST_SHIFT;
            divCnt <= '0;
            bitCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (divDone) begin
            divCnt <= '0;
            sclkQ  <= !sclkQ;
            if (sclkQ) begin
              if (lastBit) begin
                if (lastByte) begin
                  state <= ST_TAIL;
                end else begin
                  state <= ST_LOAD;
                end
                if (isData) dataLeft <= dataLeft - LEN_ONE;
                else        hdrCnt   <= hdrCnt + 2'd1;
              end else begin
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: begin
          if (divDone) begin
            state  <= ST_IDLE;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/addr_spi_master.sv
module addr_spi_master
  import asm_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [15:0]      reqOffset,
  input  logic [4:0]       reqBlock,
  input  logic             reqWrite,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             busy,
  output logic             errPulse,
  output logic             sclk,
  output logic             csN,
  output logic             mosi,
  input  logic             miso
);

  dpStrobe_t strobe;

  asm_control #(.HALF_DIV(HALF_DIV), .LEN_W(LEN_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqLen   (reqLen),
    .wrValid  (wrValid),
    .reqReady (reqReady),
    .wrReady  (wrReady),
    .strobe   (strobe),
    .sclk     (sclk),
    .csN      (csN),
    .busy     (busy),
    .errPulse (errPulse)
  );

  asm_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqOffset (reqOffset),
    .reqBlock  (reqBlock),
    .reqWrite  (reqWrite),
    .wrData    (wrData),
    .miso      (miso),
    .mosi      (mosi),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: rtl/asm_checker.sv
module asm_checker #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic errPulse,
  input logic rdValid,
  input logic wrReady,
  input logic wrValid
);

  logic [15:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     highCnt <= '0;
    else if (sclk) highCnt <= highCnt + 16'd1;
    else           highCnt <= '0;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);  // R7

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));  // R7

  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> (highCnt == 16'(HALF_DIV)));  // R8

  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (csN && !busy));  // R6

  AST_READ_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !csN);  // R5

  AST_WR_STALL_NO_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (wrReady && !wrValid) |=> !sclk);  // R10

endmodule

bind addr_spi_master asm_checker #(.HALF_DIV(HALF_DIV)) u_asm_checker (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .sclk     (sclk),
  .mosi     (mosi),
  .busy     (busy),
  .errPulse (errPulse),
  .rdValid  (rdValid),
  .wrReady  (wrReady),
  .wrValid  (wrValid)
);

// File: tb/tb_addr_spi_master.sv
module tb_addr_spi_master;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int LW         = 8;
  localparam int MAXB       = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [15:0]   reqOffset = '0;
  logic [4:0]    reqBlock = '0;
  logic          reqWrite = 1'b0;
  logic [LW-1:0] reqLen = '0;
  logic [7:0]    wrData = '0;
  logic          wrValid = 1'b0;
  logic          wrReady;
  logic [7:0]    rdData;
  logic          rdValid;
  logic          busy, errPulse, sclk, csN, mosi;
  logic          miso = 1'b0;

  addr_spi_master #(.HALF_DIV(HALF), .LEN_W(LW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expCtrl(input logic [4:0] blk, input logic wr);
    return {blk, wr, 2'b00};
  endfunction

  // Shared frame buffers (filled by the test task before a frame starts)
  logic [7:0] wrBuf   [MAXB];
  logic [7:0] misoBuf [MAXB];
  int  wrCount = 0;
  bit  stallOn = 0;
  int  frameSeq = 0;

  // Slave / monitor state
  logic [7:0] gotBytes [MAXB];
  logic [7:0] rdGot    [MAXB];
  int  byteN = 0, bitN = 0, rdN = 0, frameDone = 0, frameLen = 0;
  int  highLen = 0;
  logic [7:0] curByte = '0;
  logic prevSclk = 1'b0, prevCs = 1'b1, prevMosi = 1'b0;
  int  monSeq = 0;

  function automatic logic misoBitAt(input int b);
    int idx = b / 8;
    return (idx < MAXB) ? misoBuf[idx][7 - (b % 8)] : 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (monSeq != frameSeq) begin
        monSeq = frameSeq;
        rdN = 0;
      end
      if (!csN && prevCs) begin
        byteN = 0; bitN = 0;
        miso = misoBitAt(0);
      end
      if (csN) check(!sclk, "R7 sclk low when idle", {31'd0, sclk}, 32'd0);
      if (sclk && prevSclk)
        check(mosi == prevMosi, "R7 mosi steady while sclk high", {31'd0, mosi}, {31'd0, prevMosi});
      if (sclk) highLen++;
      if (!csN && sclk && !prevSclk) begin
        curByte = {curByte[6:0], mosi};
        bitN++;
        if (bitN % 8 == 0) begin
          if (byteN < MAXB) gotBytes[byteN] = curByte;
          byteN++;
        end
      end
      if (!sclk && prevSclk) begin
        check(highLen == HALF, "R8 sclk high phase length", highLen, HALF);
        highLen = 0;
        if (!csN) miso = misoBitAt(bitN);
      end
      if (csN && !prevCs) begin
        frameLen = byteN;
        frameDone++;
      end
      if (rdValid) begin
        if (rdN < MAXB) rdGot[rdN] = rdData;
        rdN++;
      end
      prevSclk = sclk; prevCs = csN; prevMosi = mosi;
    end
  end

  // Write stream source
  int  wrIdx = 0;
  bit  takeFlag = 0;
  int  feedSeq = 0;
  always @(negedge clk) begin
    if (feedSeq != frameSeq) begin
      feedSeq = frameSeq; wrIdx = 0; takeFlag = 0;
    end
    if (takeFlag) wrIdx++;
    wrValid = (wrIdx < wrCount) && (!stallOn || ($urandom % 3 != 0));
    wrData  = (wrIdx < MAXB) ? wrBuf[wrIdx] : 8'h00;
    takeFlag = wrValid && wrReady;
  end

  task automatic runFrame(input logic [15:0] off, input logic [4:0] blk, input logic wr,
                          input int len, input bit stall);
    int startDone;
    int t;
    for (int i = 0; i < MAXB; i++) begin
      wrBuf[i]   = 8'($urandom);
      misoBuf[i] = (i < 3) ? 8'hC3 : 8'($urandom);
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    frameSeq++;
    wrCount  = wr ? len : 0;
    stallOn  = stall;
    startDone = frameDone;
    reqValid = 1'b1; reqOffset = off; reqBlock = blk; reqWrite = wr; reqLen = LW'(len);
    @(negedge clk);
    reqValid = 1'b0; reqOffset = ~off; reqBlock = ~blk; reqWrite = ~wr; reqLen = LW'(len + 3);
    if (len == 0) begin
      check(errPulse == 1'b1, "R6 error pulse on zero length", {31'd0, errPulse}, 32'd1);
      check(csN && !busy, "R6 no frame on zero length", {30'd0, csN, busy}, 32'd2);
      @(negedge clk);
      check(errPulse == 1'b0, "R6 error pulse one cycle", {31'd0, errPulse}, 32'd0);
      repeat (10) @(negedge clk);
      check(frameDone == startDone, "R6 no chip select activity", frameDone, startDone);
      return;
    end
    check(busy && !csN && !reqReady, "R9 busy after acceptance", {29'd0, busy, csN, reqReady}, 32'd4);
    t = 0;
    while (frameDone == startDone && t < 20000) begin
      @(negedge clk);
      if (!csN) check(busy, "R9 busy while csN low", {31'd0, busy}, 32'd1);
      t++;
    end
    check(t < 20000, "R9 frame completes", t, 0);
    repeat (2) @(negedge clk);
    check(frameLen == len + 3, "R4 frame byte count", frameLen, len + 3);
    check(gotBytes[0] == off[15:8], "R2 offset high byte", gotBytes[0], off[15:8]);
    check(gotBytes[1] == off[7:0],  "R2 offset low byte", gotBytes[1], off[7:0]);
    check(gotBytes[2] == expCtrl(blk, wr), "R3 control byte", gotBytes[2], expCtrl(blk, wr));
    for (int i = 0; i < len && i + 3 < MAXB; i++) begin
      if (wr) check(gotBytes[i+3] == wrBuf[i], stall ? "R10 data after stall" : "R4 write data",
                    gotBytes[i+3], wrBuf[i]);
      else    check(gotBytes[i+3] == 8'h00, "R5 read filler", gotBytes[i+3], 0);
    end
    if (wr) begin
      check(wrIdx == len, "R4 write words consumed", wrIdx, len);
      check(rdN == 0, "R5 no read strobe on write", rdN, 0);
    end else begin
      check(rdN == len, "R5 read byte count", rdN, len);
      for (int i = 0; i < len && i < rdN && i + 3 < MAXB; i++)
        check(rdGot[i] == misoBuf[i+3], "R5 read data", rdGot[i], misoBuf[i+3]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b0, "R1 reset bus idle", {30'd0, csN, sclk}, 32'd2);
    check(!busy && !errPulse && reqReady, "R1 reset flags", {29'd0, busy, errPulse, reqReady}, 32'd1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(csN && !sclk && !busy && reqReady, "R1 idle after reset", {28'd0, csN, sclk, busy, reqReady}, 32'h9);

    runFrame(16'h0040, 5'b00110, 1'b1, 4, 0);   // R2 R3 transmit-area write
    runFrame(16'h0001, 5'b00000, 1'b1, 4, 0);   // R4 common-area burst
    runFrame(16'h0001, 5'b00000, 1'b0, 4, 0);   // R5 same offset, read
    runFrame(16'hFFFF, 5'b11111, 1'b0, 1, 0);   // R5 single byte, all ones header
    runFrame(16'h1234, 5'b01010, 1'b1, 0, 0);   // R6 zero length write
    runFrame(16'h5678, 5'b00101, 1'b0, 0, 0);   // R6 zero length read
    runFrame(16'h8001, 5'b10001, 1'b1, 40, 1);  // R10 long write with stalls
    runFrame(16'h0000, 5'b00000, 1'b1, 1, 1);   // R10 single stalled byte

    for (int n = 0; n < 24; n++) begin
      runFrame(16'($urandom), 5'($urandom), 1'($urandom), 1 + int'($urandom % 20), 1'($urandom));
    end

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule